// File: doc/BRIEF.md
# Registered Command Buffer with Parity

This block sits between a memory controller and the DRAM devices of a registered memory module. On every rising clock edge it captures the command word, clock-enable, on-die-termination and chip-select inputs, and drives each captured value onto two separate output copies, A and B. Each copy feeds one half of the module's devices. The command word holds the row/column address, the bank address and the row-strobe, column-strobe and write-enable command bits.

The controller sends a parity bit with every command word. The block checks even parity across the command word and that bit. The clock-enable, termination and chip-select lines are module-dependent, so they are not part of the check. A check is made only when the captured word selects at least one device. A failed check drives an active-low error output low, and that output is held low for a fixed number of cycles.

A static strap picks one of two chip-select arrangements. In dual mode the strap is high, and two chip selects are each copied to both sides. In quad mode the strap is low, and four chip selects each drive exactly one output. A synchronous reset puts every output into a defined idle state.

Top module: `rcb_cmd_buffer`

## Requirements
- R1: After each rising edge with reset high, `qa_cmd` and `qb_cmd` both equal the `d_cmd` value present at that edge, and the same holds for `qa_cke`/`qb_cke` from `d_cke` and for `qa_odt`/`qb_odt` from `d_odt`. The bit layout of `d_cmd` is: bits [ROW_W-1:0] address, then BANK_W bank bits, then the three command-strobe bits at the top.
- R2: With `quad_cs_n` = 1 (dual mode), `qa_cs_n` and `qb_cs_n` both equal `d_cs_n[1:0]` after the edge. `d_cs_n[3:2]` has no effect on any output.
- R3: With `quad_cs_n` = 0 (quad mode), `qa_cs_n[1:0]` equals `d_cs_n[1:0]` and `qb_cs_n[1:0]` equals `d_cs_n[3:2]` after the edge.
- R4: A word is in error when the XOR of all `d_cmd` bits and `d_par` is 1, meaning the total count of ones is odd. For a word in error that is captured at edge k, `err_n` goes low after edge k+1. A word with an even count of ones never causes `err_n` to go low.
- R5: `d_cke`, `d_odt` and `d_cs_n` are not part of the parity sum. Changing them does not change the error result for a word that selects a device.
- R6: A word is checked only when at least one effective chip select is low. In dual mode the effective chip selects are `d_cs_n[1:0]`; in quad mode they are all four bits. An idle word with bad parity never drives `err_n` low.
- R7: After a detected error, `err_n` stays low for HOLD_CYC cycles (default 2). A further error detected during that window restarts the full window.
- R8: While `rst_n` is low at an edge, the following outputs take these values after that edge: every command, clock-enable and termination output 0, every chip-select output 1, `err_n` 1. Any pending error or hold window is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| quad_cs_n | input | 1 | Static strap: 1 = dual chip-select mode, 0 = quad mode |
| d_cmd | input | ROW_W+BANK_W+3 | Command word: address, bank and strobe bits |
| d_cke | input | CKE_W | Clock-enable inputs |
| d_odt | input | ODT_W | On-die-termination inputs |
| d_cs_n | input | 4 | Chip-select inputs, active low |
| d_par | input | 1 | Even-parity bit for d_cmd |
| qa_cmd | output | ROW_W+BANK_W+3 | Command word, copy A |
| qb_cmd | output | ROW_W+BANK_W+3 | Command word, copy B |
| qa_cke | output | CKE_W | Clock enables, copy A |
| qb_cke | output | CKE_W | Clock enables, copy B |
| qa_odt | output | ODT_W | Termination, copy A |
| qb_odt | output | ODT_W | Termination, copy B |
| qa_cs_n | output | 2 | Chip selects, side A |
| qb_cs_n | output | 2 | Chip selects, side B |
| err_n | output | 1 | Parity error, active low, held |

## Verification
The copy registers are loaded directly from the inputs. A corrupted A or B bit, or a chip select mapped to the wrong side, therefore shows at the ports on the first edge after the bad value is latched. The two copies disagree, or a side-B chip select fails to follow its source. Internal errors in the parity path take longer to show. A wrong parity or activity flag appears on `err_n` one edge later than a copy error would. A wrong hold counter appears only as an error window that is too short, too long or not restarted. For that reason the bench counts the exact low cycles after single, back-to-back and reset-interrupted errors.

// File: rtl/rcb_pkg.sv
`timescale 1ns/1ps
package rcb_pkg;
    // number of chip-select input pins and outputs per side
    localparam int CS_IN_N    = 4;
    localparam int CS_SIDE_N  = 2;
    localparam int STROBE_N   = 3;

    typedef enum logic {
        CS_QUAD = 1'b0,
        CS_DUAL = 1'b1
    } cs_mode_e;
endpackage

// File: rtl/rcb_cs_map.sv
`timescale 1ns/1ps
module rcb_cs_map
    import rcb_pkg::*;
(
    input  logic                  mode_i,
    input  logic [CS_IN_N-1:0]    cs_n_i,
    output logic [CS_SIDE_N-1:0]  side_a_o,
    output logic [CS_SIDE_N-1:0]  side_b_o,
    output logic                  active_o
);
    cs_mode_e mode;
    assign mode = cs_mode_e'(mode_i);

    for (genvar i = 0; i < CS_SIDE_N; i++) begin : g_side
        assign side_a_o[i] = cs_n_i[i];
        assign side_b_o[i] = (mode == CS_DUAL) ? cs_n_i[i] : cs_n_i[CS_SIDE_N + i];
    end

    // effective selects: lower pair in dual mode, all pins in quad mode
    assign active_o = (mode == CS_DUAL) ? ~(&cs_n_i[CS_SIDE_N-1:0]) : ~(&cs_n_i);
endmodule

// File: rtl/rcb_parity.sv
`timescale 1ns/1ps
module rcb_parity #(
    parameter int W = 22
) (
    input  logic [W-1:0] data_i,
    input  logic         par_i,
    output logic         odd_o
);
    localparam int TOT = W + 1;
    logic [TOT-1:0] chain;

    // ripple reduction kept explicit so each stage is visible in the netlist
    assign chain[0] = par_i;
    for (genvar i = 0; i < W; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ data_i[i];
    end
    assign odd_o = chain[TOT-1];
endmodule

// File: rtl/rcb_err_hold.sv
`timescale 1ns/1ps
module rcb_err_hold #(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_i,
    output logic err_n_o
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (det_i) begin
            h_d.cnt = HOLD_V;
        end else if (h_q.cnt != '0) begin
            h_d.cnt = h_q.cnt - CNT_W'(1);
        end
        if (!rst_n) begin
            h_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        h_q <= h_d;
    end

    assign err_n_o = (h_q.cnt == '0);

    // R7
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_i |=> (h_q.cnt == HOLD_V) && !err_n_o);

    // R7
    hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.cnt <= HOLD_V);

    // R7
    hold_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_i && h_q.cnt != '0) |=> h_q.cnt == $past(h_q.cnt) - CNT_W'(1));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!det_i && h_q.cnt == '0) |=> err_n_o);
endmodule

// File: rtl/rcb_cmd_buffer.sv
`timescale 1ns/1ps
module rcb_cmd_buffer
    import rcb_pkg::*;
#(
    parameter int ROW_W    = 16,
    parameter int BANK_W   = 3,
    parameter int CKE_W    = 2,
    parameter int ODT_W    = 2,
    parameter int HOLD_CYC = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            quad_cs_n,
    input  logic [ROW_W+BANK_W+STROBE_N-1:0] d_cmd,
    input  logic [CKE_W-1:0]                d_cke,
    input  logic [ODT_W-1:0]                d_odt,
    input  logic [CS_IN_N-1:0]              d_cs_n,
    input  logic                            d_par,
    output logic [ROW_W+BANK_W+STROBE_N-1:0] qa_cmd,
    output logic [ROW_W+BANK_W+STROBE_N-1:0] qb_cmd,
    output logic [CKE_W-1:0]                qa_cke,
    output logic [CKE_W-1:0]                qb_cke,
    output logic [ODT_W-1:0]                qa_odt,
    output logic [ODT_W-1:0]                qb_odt,
    output logic [CS_SIDE_N-1:0]            qa_cs_n,
    output logic [CS_SIDE_N-1:0]            qb_cs_n,
    output logic                            err_n
);
    localparam int CMD_W = ROW_W + BANK_W + STROBE_N;

    typedef struct packed {
        logic [CMD_W-1:0]     cmd_a;
        logic [CMD_W-1:0]     cmd_b;
        logic [CKE_W-1:0]     cke_a;
        logic [CKE_W-1:0]     cke_b;
        logic [ODT_W-1:0]     odt_a;
        logic [ODT_W-1:0]     odt_b;
        logic [CS_SIDE_N-1:0] cs_a;
        logic [CS_SIDE_N-1:0] cs_b;
        logic                 chk_act;
        logic                 chk_odd;
    } cap_t;

    cap_t st_d, st_q;

    logic [CS_SIDE_N-1:0] cs_a_w, cs_b_w;
    logic                 cs_act_w;
    logic                 par_odd_w;
    logic                 det_w;

    rcb_cs_map u_cs (
        .mode_i   (quad_cs_n),
        .cs_n_i   (d_cs_n),
        .side_a_o (cs_a_w),
        .side_b_o (cs_b_w),
        .active_o (cs_act_w)
    );

    rcb_parity #(.W(CMD_W)) u_par (
        .data_i (d_cmd),
        .par_i  (d_par),
        .odd_o  (par_odd_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.cmd_a   = d_cmd;
        st_d.cmd_b   = d_cmd;
        st_d.cke_a   = d_cke;
        st_d.cke_b   = d_cke;
        st_d.odt_a   = d_odt;
        st_d.odt_b   = d_odt;
        st_d.cs_a    = cs_a_w;
        st_d.cs_b    = cs_b_w;
        st_d.chk_act = cs_act_w;
        st_d.chk_odd = par_odd_w;
        if (!rst_n) begin
            st_d.cmd_a   = '0;
            st_d.cmd_b   = '0;
            st_d.cke_a   = '0;
            st_d.cke_b   = '0;
            st_d.odt_a   = '0;
            st_d.odt_b   = '0;
            st_d.cs_a    = '1;
            st_d.cs_b    = '1;
            st_d.chk_act = 1'b0;
            st_d.chk_odd = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // error on the word captured one edge earlier, only when it selected a device
    assign det_w = st_q.chk_act & st_q.chk_odd;

    rcb_err_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .det_i   (det_w),
        .err_n_o (err_n)
    );

    assign qa_cmd  = st_q.cmd_a;
    assign qb_cmd  = st_q.cmd_b;
    assign qa_cke  = st_q.cke_a;
    assign qb_cke  = st_q.cke_b;
    assign qa_odt  = st_q.odt_a;
    assign qb_odt  = st_q.odt_b;
    assign qa_cs_n = st_q.cs_a;
    assign qb_cs_n = st_q.cs_b;

    // R1
    copy_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qa_cmd == qb_cmd) && (qa_cke == qb_cke) && (qa_odt == qb_odt));

    // R1
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (qa_cmd == $past(d_cmd)) && (qb_cke == $past(d_cke))
                  && (qa_odt == $past(d_odt)));

    // R2
    dual_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && quad_cs_n) |=> (qa_cs_n == $past(d_cs_n[1:0]))
                                 && (qb_cs_n == $past(d_cs_n[1:0])));

    // R3
    quad_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !quad_cs_n) |=> (qa_cs_n == $past(d_cs_n[1:0]))
                                  && (qb_cs_n == $past(d_cs_n[3:2])));

    // R8
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (qa_cmd == '0) && (qb_cmd == '0) && (&qa_cs_n) && (&qb_cs_n) && err_n);
endmodule

// File: tb/sim_rcb_cmd_buffer.sv
`timescale 1ns/1ps
module sim_rcb_cmd_buffer;
    localparam int ROW_W = 16, BANK_W = 3, CKE_W = 2, ODT_W = 2, HOLD = 2;
    localparam int CMD_W = ROW_W + BANK_W + 3;

    logic clk = 1'b0;
    logic rst_n, quad_cs_n, d_par;
    logic [CMD_W-1:0] d_cmd;
    logic [CKE_W-1:0] d_cke;
    logic [ODT_W-1:0] d_odt;
    logic [3:0] d_cs_n;
    logic [CMD_W-1:0] qa_cmd, qb_cmd;
    logic [CKE_W-1:0] qa_cke, qb_cke;
    logic [ODT_W-1:0] qa_odt, qb_odt;
    logic [1:0] qa_cs_n, qb_cs_n;
    logic err_n;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // expected model state
    logic [CMD_W-1:0] e_cmd;
    logic [CKE_W-1:0] e_cke;
    logic [ODT_W-1:0] e_odt;
    logic [1:0] e_csa, e_csb;
    int  e_cnt = 0;
    bit  e_det = 0;

    always #2.5 clk = ~clk;

    rcb_cmd_buffer #(.ROW_W(ROW_W), .BANK_W(BANK_W), .CKE_W(CKE_W),
                     .ODT_W(ODT_W), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .quad_cs_n(quad_cs_n), .d_cmd(d_cmd),
        .d_cke(d_cke), .d_odt(d_odt), .d_cs_n(d_cs_n), .d_par(d_par),
        .qa_cmd(qa_cmd), .qb_cmd(qb_cmd), .qa_cke(qa_cke), .qb_cke(qb_cke),
        .qa_odt(qa_odt), .qb_odt(qb_odt), .qa_cs_n(qa_cs_n), .qb_cs_n(qb_cs_n),
        .err_n(err_n));

    function automatic bit word_odd(logic [CMD_W-1:0] c, logic p);
        return ^{c, p};
    endfunction

    function automatic bit word_active(bit dual, logic [3:0] cs);
        return dual ? (cs[1:0] != 2'b11) : (cs != 4'b1111);
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cycle(logic rst, logic [CMD_W-1:0] cmd, logic [CKE_W-1:0] cke,
                         logic [ODT_W-1:0] odt, logic [3:0] cs, logic par, string etag);
        string dtag, ctag;
        @(negedge clk);
        rst_n = rst; d_cmd = cmd; d_cke = cke; d_odt = odt; d_cs_n = cs; d_par = par;
        @(posedge clk);
        if (!rst) begin
            e_cmd = '0; e_cke = '0; e_odt = '0; e_csa = 2'b11; e_csb = 2'b11;
            e_cnt = 0; e_det = 0;
        end else begin
            e_cnt = e_det ? HOLD : (e_cnt > 0 ? e_cnt - 1 : 0);
            e_det = word_active(quad_cs_n, cs) && word_odd(cmd, par);
            e_cmd = cmd; e_cke = cke; e_odt = odt;
            e_csa = cs[1:0];
            e_csb = quad_cs_n ? cs[1:0] : cs[3:2];
        end
        #1;
        dtag = rst ? "R1" : "R8";
        ctag = !rst ? "R8" : (quad_cs_n ? "R2" : "R3");
        check(dtag, "qa_cmd", 64'(qa_cmd), 64'(e_cmd));
        check(dtag, "qb_cmd", 64'(qb_cmd), 64'(e_cmd));
        check(dtag, "qa_cke/qb_cke", 64'({qa_cke, qb_cke}), 64'({e_cke, e_cke}));
        check(dtag, "qa_odt/qb_odt", 64'({qa_odt, qb_odt}), 64'({e_odt, e_odt}));
        check(ctag, "qa_cs_n", 64'(qa_cs_n), 64'(e_csa));
        check(ctag, "qb_cs_n", 64'(qb_cs_n), 64'(e_csb));
        check(rst ? etag : "R8", "err_n", 64'(err_n), 64'(e_cnt == 0));
    endtask

    task automatic word(logic [3:0] cs, bit bad, string etag);
        logic [CMD_W-1:0] c = CMD_W'($urandom);
        cycle(1'b1, c, CKE_W'($urandom), ODT_W'($urandom), cs, (^c) ^ bad, etag);
    endtask

    task automatic idle(int n, string etag);
        for (int i = 0; i < n; i++) word(4'b1111, 1'b0, etag);
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            word(4'($urandom), ($urandom % 10) < 3, "R4");
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        quad_cs_n = 1'b1;
        // R8: reset with garbage inputs
        for (int i = 0; i < 3; i++)
            cycle(1'b0, CMD_W'($urandom), '1, '1, 4'b0000, 1'b1, "R8");

        // dual mode
        // R6: idle words with bad parity never flag
        for (int i = 0; i < 3; i++) word(4'b1111, 1'b1, "R6");
        // R6/R2: upper selects low are ignored in dual mode
        for (int i = 0; i < 3; i++) word(4'b0011, 1'b1, "R6");
        // R5: sideband lines vary, command parity good
        for (int i = 0; i < 6; i++) word(4'b1110, 1'b0, "R5");
        // R7: single error, then window length
        word(4'b1101, 1'b1, "R7");
        idle(4, "R7");
        // R7: retrigger inside the window
        word(4'b1110, 1'b1, "R7");
        idle(1, "R7");
        word(4'b1110, 1'b1, "R7");
        idle(4, "R7");
        random_run(400);

        // R8: reset in the middle of a hold window
        word(4'b1100, 1'b1, "R4");
        idle(1, "R4");
        cycle(1'b0, '0, '0, '0, 4'b1111, 1'b0, "R8");
        idle(3, "R8");

        // quad mode
        quad_cs_n = 1'b0;
        idle(2, "R3");
        // R3/R4: upper selects alone now count as active
        word(4'b0011, 1'b1, "R4");
        idle(3, "R4");
        // R5 in quad mode
        for (int i = 0; i < 6; i++) word(4'b0111, 1'b0, "R5");
        random_run(400);
        idle(4, "R4");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule